// File: doc/BRIEF.md
# Hamming SEC-DED Codec for a 4-bit Memory Word

This block guards a 4-bit data word on its way into and back out of a memory. The encoder side turns four data bits into an 8-bit protected word, combinationally. Three of the bits are positional parity bits and one is a whole-word parity bit. The word is stored as it is. When it comes back, possibly damaged, it goes to the decoder side.

The decoder recomputes the three check bits and the whole-word parity. When exactly one bit has flipped, the check bits, read as a binary number, name the position of that bit. The decoder flips it back and returns the original data. When two bits have flipped, the check bits are non-zero but the whole-word parity is even. The decoder flags this case and does not try to repair the word. The decoded result goes through one register stage that loads only while the caller marks the input word valid.

Top module: `secded_codec`

## Requirements
- R1: Code word bit index i holds position i+1. Positions 1, 2 and 4 (bits 0, 1, 3) are parity bits. Data bit 0 sits at position 3 (bit 2), data bit 1 at position 5 (bit 4), data bit 2 at position 6 (bit 5) and data bit 3 at position 7 (bit 6). The parity bit at position 2^k makes the set of positions 1..7 whose index has bit k set even, including that parity bit.
- R2: Bit 7 (position 8) makes the full 8-bit word even.
- R3: The syndrome output s has bit k equal to the parity of the positions among 1..7 that have bit k set. For a single flip at position j in 1..7, s equals j.
- R4: With a single flip at any position 1..7, the decoder returns the original data, sets the corrected flag and clears the double flag.
- R5: A flip of bit 7 alone gives syndrome 0, sets the corrected flag, and returns the stored data unchanged.
- R6: Any two flipped bits set the double flag and clear the corrected flag. The syndrome is then the XOR of the positions of the flipped bits among 1..7 (non-zero), and the data output carries the raw bits at positions 3, 5, 6 and 7 without correction.
- R7: A clean word gives syndrome 0, both flags clear and the stored data.
- R8: The corrected and double flags are never high together.
- R9: When the input valid is high at a clock edge, the decoded outputs and the output valid show that word from that edge on. When the input valid is low, the decoded outputs hold their values and the output valid is low.
- R10: While reset is active, and until it has been released through the two-flop synchronizer, the output valid, both flags, the syndrome and the data output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 4 | Data word to protect |
| enc_code_o | output | 8 | Protected word for storage |
| dec_valid_i | input | 1 | Read-back word is valid this cycle |
| dec_code_i | input | 8 | Protected word read back from storage |
| dec_valid_o | output | 1 | Decoded result updated this cycle |
| dec_data_o | output | 4 | Corrected data, or raw data on a double error |
| dec_syndrome_o | output | 3 | Check bits, binary position of a single error |
| dec_sec_o | output | 1 | A single error was corrected |
| dec_ded_o | output | 1 | A double error was detected and left uncorrected |

## Verification
An error is never made by the block itself. In a real system the word only reaches the decoder damaged, so the damage has to be injected between the two halves. The bench takes each encoder output for all 16 data values and XORs a mask onto it before feeding it to the decoder. The masks are the empty mask, all eight single-bit masks and all 28 two-bit masks. This set includes the flip of the whole-word parity bit alone and the pairs that involve it, where the syndrome is the position of the other bit only. Hold behaviour is checked by changing the input word while the input valid is low.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W  = 4;
  localparam int CHK_W   = 3;
  localparam int POS_MAX = (1 << CHK_W) - 1;
  localparam int CODE_W  = POS_MAX + 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    data_t data;
    chk_t  syn;
    logic  sec;
    logic  ded;
  } dec_res_t;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // position (1-based) of data bit k: k-th non power-of-two slot
  function automatic int data_pos(input int k);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= POS_MAX; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == k) return p;
        cnt++;
      end
    end
    return 0;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  code_t w;

  always_comb begin
    w = '0;
    for (int k = 0; k < DATA_W; k++) begin
      w[data_pos(k)-1] = data_i[k];
    end
    for (int b = 0; b < CHK_W; b++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= POS_MAX; p++) begin
        if (((p >> b) & 1) == 1 && !is_pow2(p)) par = par ^ w[p-1];
      end
      w[(1 << b) - 1] = par;
    end
    w[CODE_W-1] = ^w[CODE_W-2:0];
  end

  assign code_o = w;
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  code_t code_i,
  output chk_t  syn_o,
  output logic  odd_o
);
  always_comb begin
    syn_o = '0;
    for (int b = 0; b < CHK_W; b++) begin
      for (int p = 1; p <= POS_MAX; p++) begin
        if (((p >> b) & 1) == 1) syn_o[b] = syn_o[b] ^ code_i[p-1];
      end
    end
  end

  assign odd_o = ^code_i;
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
(
  input  code_t    code_i,
  input  chk_t     syn_i,
  input  logic     odd_i,
  output dec_res_t res_o
);
  code_t fixed;
  data_t raw_d;
  data_t fix_d;
  logic  dbl;

  always_comb begin
    fixed = code_i;
    if (odd_i) begin
      for (int p = 1; p <= POS_MAX; p++) begin
        if (syn_i == CHK_W'(p)) fixed[p-1] = ~code_i[p-1];
      end
    end
    for (int k = 0; k < DATA_W; k++) begin
      raw_d[k] = code_i[data_pos(k)-1];
      fix_d[k] = fixed[data_pos(k)-1];
    end
  end

  assign dbl = !odd_i && (syn_i != '0);

  assign res_o.data = dbl ? raw_d : fix_d;
  assign res_o.syn  = syn_i;
  assign res_o.sec  = odd_i;
  assign res_o.ded  = dbl;

  // p_ded_nonzero_r6: a double report always comes with a non-zero syndrome
  always_comb begin
    if (!$isunknown(res_o)) begin
      p_ded_nonzero_r6: assert (!res_o.ded || (syn_i != '0));
    end
  end

  // p_p4_passthru_r5: whole-word parity flip alone leaves data bits untouched
  always_comb begin
    if (!$isunknown(code_i) && !$isunknown(syn_i)) begin
      if (odd_i && syn_i == '0) begin
        p_p4_passthru_r5: assert (res_o.data == raw_d);
      end
    end
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  enc_data_i,
  output logic [7:0]  enc_code_o,
  input  logic        dec_valid_i,
  input  logic [7:0]  dec_code_i,
  output logic        dec_valid_o,
  output logic [3:0]  dec_data_o,
  output logic [2:0]  dec_syndrome_o,
  output logic        dec_sec_o,
  output logic        dec_ded_o
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  chk_t       syn;
  logic       odd;
  dec_res_t   res_d;
  dec_res_t   res_q;
  logic       vld_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  secded_enc u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_syndrome u_syn (
    .code_i (dec_code_i),
    .syn_o  (syn),
    .odd_o  (odd)
  );

  secded_fix u_fix (
    .code_i (dec_code_i),
    .syn_i  (syn),
    .odd_i  (odd),
    .res_o  (res_d)
  );

  generate
    if (OUT_REG) begin : g_reg
      dec_res_t res_nxt;

      always_comb begin
        res_nxt = res_q;
        if (dec_valid_i) res_nxt = res_d;
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n) begin
          res_q <= '0;
          vld_q <= 1'b0;
        end else begin
          res_q <= res_nxt;
          vld_q <= dec_valid_i;
        end
      end

      p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
        !(res_q.sec && res_q.ded));
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
        !dec_valid_i |=> $stable(res_q) && !vld_q);
      p_load_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
        dec_valid_i |=> vld_q && (res_q == $past(res_d)));
    end else begin : g_comb
      assign res_q = res_d;
      assign vld_q = dec_valid_i;
    end
  endgenerate

  assign dec_valid_o    = vld_q;
  assign dec_data_o     = res_q.data;
  assign dec_syndrome_o = res_q.syn;
  assign dec_sec_o      = res_q.sec;
  assign dec_ded_o      = res_q.ded;
endmodule

// File: tb/tb_secded_codec.sv
module tb_secded_codec;
  logic       clk;
  logic       rst_n;
  logic [3:0] enc_data_i;
  logic [7:0] enc_code_o;
  logic       dec_valid_i;
  logic [7:0] dec_code_i;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_sec_o;
  logic       dec_ded_o;

  int checks;
  int errors;
  bit done;

  secded_codec dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_data_i     (enc_data_i),
    .enc_code_o     (enc_code_o),
    .dec_valid_i    (dec_valid_i),
    .dec_code_i     (dec_code_i),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_sec_o      (dec_sec_o),
    .dec_ded_o      (dec_ded_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference encoder from positional rules (R1, R2)
  function automatic logic [7:0] ref_enc(input logic [3:0] d);
    logic [7:0] w;
    w = 8'h00;
    w[2] = d[0]; w[4] = d[1]; w[5] = d[2]; w[6] = d[3];
    w[0] = w[2] ^ w[4] ^ w[6];
    w[1] = w[2] ^ w[5] ^ w[6];
    w[3] = w[4] ^ w[5] ^ w[6];
    w[7] = ^w[6:0];
    return w;
  endfunction

  function automatic logic [3:0] raw_bits(input logic [7:0] w);
    return {w[6], w[5], w[4], w[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs as one vector {valid, data, syn, sec, ded}
  function automatic logic [9:0] outv();
    return {dec_valid_o, dec_data_o, dec_syndrome_o, dec_sec_o, dec_ded_o};
  endfunction

  task automatic decode(input logic [7:0] w, input logic [3:0] ed,
                        input logic [2:0] es, input bit esec, input bit eded,
                        input string req);
    logic [9:0] e;
    dec_code_i  = w;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    e = {1'b1, ed, es, esec, eded};
    chk(outv() == e, req, 32'(outv()), 32'(e));
    chk(!(dec_sec_o && dec_ded_o), "R8", 32'({dec_sec_o, dec_ded_o}), 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; enc_data_i = 4'h0; dec_valid_i = 1'b0; dec_code_i = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state while reset is held, with a valid word applied
    dec_valid_i = 1'b1; dec_code_i = 8'hff;
    @(negedge clk);
    chk(outv() == 10'h0, "R10", 32'(outv()), 32'h0);
    dec_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(outv() == 10'h0, "R10", 32'(outv()), 32'h0);
    repeat (3) @(negedge clk);

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      enc_data_i = 4'(d);
      #1;
      cw = ref_enc(4'(d));
      chk(enc_code_o[6:0] == cw[6:0], "R1", 32'(enc_code_o), 32'(cw));
      chk(enc_code_o[7] == cw[7] && ^enc_code_o == 1'b0, "R2",
          32'(enc_code_o), 32'(cw));
      // R7: clean word
      decode(enc_code_o, 4'(d), 3'd0, 1'b0, 1'b0, "R7");
      // R9: hold while valid low, with a different word applied
      begin
        logic [9:0] held;
        held = outv();
        dec_code_i = ~enc_code_o;
        @(negedge clk);
        chk(outv() == {1'b0, held[8:0]}, "R9", 32'(outv()),
            32'({1'b0, held[8:0]}));
      end
      // single flips: R3/R4 for positions 1..7, R5 for position 8
      for (int j = 1; j <= 8; j++) begin
        logic [7:0] m;
        m = 8'h01 << (j - 1);
        if (j <= 7) decode(enc_code_o ^ m, 4'(d), 3'(j), 1'b1, 1'b0, "R3_R4");
        else        decode(enc_code_o ^ m, 4'(d), 3'd0, 1'b1, 1'b0, "R5");
      end
      // double flips: R6
      for (int i = 1; i <= 8; i++) begin
        for (int j = i + 1; j <= 8; j++) begin
          logic [7:0] w;
          logic [2:0] s;
          w = enc_code_o ^ (8'h01 << (i - 1)) ^ (8'h01 << (j - 1));
          s = ((i <= 7) ? 3'(i) : 3'd0) ^ ((j <= 7) ? 3'(j) : 3'd0);
          decode(w, raw_bits(w), s, 1'b0, 1'b1, "R6");
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule